// File: doc/BRIEF.md
# Duty-Cycled Receive Window Sequencer

This block controls a receiver that is polled at a low duty cycle. Each wake pulse moves the sequencer from sleep through two warm-up phases: oscillator start, then synthesizer tuning. It then enables the receiver for a listen window. The window length is the programmed count multiplied by four times two to the power of the programmed exponent, measured in cycles of the slow clock. The window count and the exponent are captured when the wake pulse is accepted, so changing the inputs later has no effect on a window that is already running.

While the receiver is enabled, the sequencer watches four handshake inputs from the receive path: preamble found, sync word found, packet complete and packet error. It closes the window early when a packet finishes or fails, or when a preamble is not followed by a sync word in time. It holds the receiver on past the window end while a reception that has already started is still in progress. Every session ends with a three-bit outcome code and a one-cycle valid strobe. The host interrupt fires only for the two outcomes that deliver a good packet.

A multi-packet option stops a false preamble from ending the window early. With the option set, the receiver keeps listening until a packet arrives or the window runs out.

Top module: `rxwin_seq`

## Requirements
- R1: While reset is asserted and right after it, `rx_en`, `outcome_vld` and `host_irq` are 0 and `phase` is 0 (sleep).
- R2: A `wake` pulse seen in sleep with `enable` high gives `phase` 1 (oscillator) for XTAL_CYC cycles, then `phase` 2 (tuning) for TUNE_CYC cycles, then `phase` 3 (listen) with `rx_en` high. With `enable` low, `wake` leaves the block in sleep.
- R3: The listen window lasts `win_len` × 4 × 2^`win_exp` cycles. A `win_len` of 0 counts as 1. Both values are sampled only on the accepted wake.
- R4: If the window expires with no preamble seen, the session ends with outcome 0 (OFF).
- R5: A `pkt_done` inside the listen window ends the session with outcome 1 (END) and raises `host_irq`.
- R6: With `multi_pkt` low, a preamble not followed by `sync_det` within SYNC_WAIT cycles ends the session with outcome 2 (ABORT). A `pkt_err` inside the window also gives outcome 2.
- R7: At window expiry the block enters `phase` 4 (prolong) with `rx_en` still high if a sync word has been seen, or if a preamble has been seen and its sync wait has not yet run out.
- R8: In prolong, `pkt_done` ends with outcome 3 (PROLONG_END) and `host_irq`. Either `pkt_err` or a run-out sync wait ends with outcome 4 (PROLONG_ABORT).
- R9: With `multi_pkt` high, a run-out sync wait during the listen window does not end the session. The window then expires with outcome 0.
- R10: Within one cycle, `pkt_err` beats `pkt_done`, `pkt_done` beats a sync-wait run-out, and all three beat window expiry. A `pkt_done` in the last window cycle gives END. A `sync_det` in the cycle the sync wait runs out still counts.
- R11: `wake` is ignored outside sleep. Detection inputs are ignored outside listen and prolong. A `sync_det` before or together with the first preamble is ignored.
- R12: `outcome_vld` is a one-cycle pulse in the first cycle with `rx_en` low after a session, and `outcome` holds its code afterwards. `host_irq` pulses with it only for codes 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Duty-cycle operation allowed |
| wake | input | 1 | Wake pulse starting a session |
| multi_pkt | input | 1 | Suppress abort on missing sync |
| win_exp | input | EXP_W | Window exponent |
| win_len | input | LEN_W | Window count |
| preamble_det | input | 1 | Preamble found by receive path |
| sync_det | input | 1 | Sync word found |
| pkt_done | input | 1 | Packet received intact |
| pkt_err | input | 1 | Packet failed |
| rx_en | output | 1 | Receiver enable |
| phase | output | 3 | 0 sleep, 1 oscillator, 2 tuning, 3 listen, 4 prolong |
| outcome | output | 3 | Last session result code |
| outcome_vld | output | 1 | Outcome strobe |
| host_irq | output | 1 | Good-packet interrupt |

## Verification
Three pairs of events can land in the same cycle, and each pair has a defined winner. A packet can complete in the very last window cycle, where the block must report END and must not prolong. A sync word can arrive in the cycle the sync wait runs out, where the sync word must rescue the session. A packet error and a packet completion can be raised together, where the error must win. The bench aims directed sessions at exactly those cycle offsets from the first listen cycle. Random sessions then scatter event offsets across and past the window boundary. Each session's outcome code and receiver-on cycle count are compared against a cycle-stepped bench model of the priority rules.

// File: rtl/rxwin_pkg.sv
package rxwin_pkg;
  typedef enum logic [2:0] {
    PH_SLEEP   = 3'd0,
    PH_XTAL    = 3'd1,
    PH_TUNE    = 3'd2,
    PH_LISTEN  = 3'd3,
    PH_PROLONG = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    OC_OFF    = 3'd0,
    OC_END    = 3'd1,
    OC_ABORT  = 3'd2,
    OC_PEND   = 3'd3,
    OC_PABORT = 3'd4
  } outcome_e;
endpackage

// File: rtl/rxwin_wtimer.sv
// Listen-window timer: captures length and exponent at session start,
// counts while running and flags the final window cycle.
module rxwin_wtimer #(
  parameter int LEN_W   = 8,
  parameter int EXP_W   = 5,
  parameter int EXP_MAX = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ld,
  input  logic [LEN_W-1:0] len_in,
  input  logic [EXP_W-1:0] exp_in,
  input  logic             run,
  output logic             expire
);
  localparam int CNT_W = LEN_W + 2 + EXP_MAX;
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EXP_MAX);

  logic [LEN_W-1:0] len_q, len_d;
  logic [EXP_W-1:0] exp_q, exp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic [EXP_W:0]   shamt;
  logic             cnt_en;

  always_comb begin
    len_d  = (len_in == '0) ? LEN_W'(1) : len_in;
    exp_d  = (exp_in > EXP_CAP) ? EXP_CAP : exp_in;
    cnt_en = cfg_ld | run;
    cnt_d  = cfg_ld ? '0 : cnt_q + CNT_W'(1);
    shamt  = {1'b0, exp_q} + (EXP_W+1)'(2);
    last   = (CNT_W'(len_q) << shamt) - CNT_W'(1);
    expire = run && (cnt_q == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= LEN_W'(1);
      exp_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cfg_ld) begin
        len_q <= len_d;
        exp_q <= exp_d;
      end
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rxwin_hunt.sv
// Tracks preamble / sync progress and the bounded wait for a sync word.
module rxwin_hunt #(
  parameter int SYNC_WAIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic active,
  input  logic preamble_det,
  input  logic sync_det,
  output logic pre_seen,
  output logic sync_seen,
  output logic hunt_exp,
  output logic hunt_to
);
  localparam int SW_W = $clog2(SYNC_WAIT) + 1;
  localparam logic [SW_W-1:0] SW_LAST = SW_W'(SYNC_WAIT - 1);

  logic            pre_q, pre_d, sync_q, sync_d, cnt_en;
  logic [SW_W-1:0] cnt_q, cnt_d;

  always_comb begin
    pre_d    = clr ? 1'b0 : (pre_q | (active & preamble_det));
    sync_d   = clr ? 1'b0 : (sync_q | (active & pre_q & sync_det));
    cnt_en   = clr | (active & pre_q & ~sync_q & (cnt_q != SW_LAST));
    cnt_d    = clr ? '0 : cnt_q + SW_W'(1);
    hunt_exp = pre_q & ~sync_q & (cnt_q == SW_LAST);
    hunt_to  = hunt_exp & ~sync_det;
  end

  assign pre_seen  = pre_q;
  assign sync_seen = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= 1'b0;
      sync_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pre_q  <= pre_d;
      sync_q <= sync_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rxwin_seq.sv
// Session sequencer: sleep -> oscillator -> tuning -> listen [-> prolong] -> sleep.
module rxwin_seq
  import rxwin_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int EXP_W     = 5,
  parameter int EXP_MAX   = 20,
  parameter int XTAL_CYC  = 20,
  parameter int TUNE_CYC  = 7,
  parameter int SYNC_WAIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wake,
  input  logic             multi_pkt,
  input  logic [EXP_W-1:0] win_exp,
  input  logic [LEN_W-1:0] win_len,
  input  logic             preamble_det,
  input  logic             sync_det,
  input  logic             pkt_done,
  input  logic             pkt_err,
  output logic             rx_en,
  output logic [2:0]       phase,
  output logic [2:0]       outcome,
  output logic             outcome_vld,
  output logic             host_irq
);
  localparam int WU_MAX = (XTAL_CYC > TUNE_CYC) ? XTAL_CYC : TUNE_CYC;
  localparam int WU_W   = $clog2(WU_MAX) + 1;
  localparam logic [WU_W-1:0] XTAL_LAST = WU_W'(XTAL_CYC - 1);
  localparam logic [WU_W-1:0] TUNE_LAST = WU_W'(TUNE_CYC - 1);

  phase_e          st_q, st_d;
  outcome_e        oc_q, close_code;
  logic            vld_q, irq_q, irq_d, close, cfg_ld;
  logic [WU_W-1:0] wu_q, wu_d;
  logic            wu_en, wu_done;
  logic            win_run, win_hit, hunt_act, hunt_clr;
  logic            pre_seen, sync_seen, hunt_exp, hunt_to;

  assign win_run  = (st_q == PH_LISTEN);
  assign hunt_act = (st_q == PH_LISTEN) || (st_q == PH_PROLONG);
  assign hunt_clr = (st_q == PH_SLEEP);

  rxwin_wtimer #(.LEN_W(LEN_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) wtimer_i (
    .clk(clk), .rst_n(rst_n), .cfg_ld(cfg_ld), .len_in(win_len),
    .exp_in(win_exp), .run(win_run), .expire(win_hit)
  );

  rxwin_hunt #(.SYNC_WAIT(SYNC_WAIT)) hunt_i (
    .clk(clk), .rst_n(rst_n), .clr(hunt_clr), .active(hunt_act),
    .preamble_det(preamble_det), .sync_det(sync_det),
    .pre_seen(pre_seen), .sync_seen(sync_seen),
    .hunt_exp(hunt_exp), .hunt_to(hunt_to)
  );

  // Warm-up phase counter
  always_comb begin
    wu_done = ((st_q == PH_XTAL) && (wu_q == XTAL_LAST)) ||
              ((st_q == PH_TUNE) && (wu_q == TUNE_LAST));
    wu_en   = (st_q == PH_XTAL) || (st_q == PH_TUNE) || (wu_q != '0);
    wu_d    = (wu_done || !((st_q == PH_XTAL) || (st_q == PH_TUNE))) ? '0
              : wu_q + WU_W'(1);
  end

  // Next-state logic
  always_comb begin
    st_d       = st_q;
    cfg_ld     = 1'b0;
    close      = 1'b0;
    close_code = OC_OFF;
    unique case (st_q)
      PH_SLEEP: begin
        if (enable && wake) begin
          st_d   = PH_XTAL;
          cfg_ld = 1'b1;
        end
      end
      PH_XTAL:  if (wu_done) st_d = PH_TUNE;
      PH_TUNE:  if (wu_done) st_d = PH_LISTEN;
      PH_LISTEN: begin
        if (pkt_err) begin
          close = 1'b1; close_code = OC_ABORT;
        end else if (pkt_done) begin
          close = 1'b1; close_code = OC_END;
        end else if (!multi_pkt && hunt_to) begin
          close = 1'b1; close_code = OC_ABORT;
        end else if (win_hit) begin
          if (sync_seen || (pre_seen && !hunt_exp)) st_d = PH_PROLONG;
          else begin
            close = 1'b1; close_code = OC_OFF;
          end
        end
      end
      PH_PROLONG: begin
        if (pkt_err) begin
          close = 1'b1; close_code = OC_PABORT;
        end else if (pkt_done) begin
          close = 1'b1; close_code = OC_PEND;
        end else if (hunt_to) begin
          close = 1'b1; close_code = OC_PABORT;
        end
      end
      default: st_d = PH_SLEEP;
    endcase
    if (close) st_d = PH_SLEEP;
    irq_d = close && ((close_code == OC_END) || (close_code == OC_PEND));
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_SLEEP;
      oc_q  <= OC_OFF;
      vld_q <= 1'b0;
      irq_q <= 1'b0;
      wu_q  <= '0;
    end else begin
      st_q  <= st_d;
      vld_q <= close;
      irq_q <= irq_d;
      if (close) oc_q <= close_code;
      if (wu_en) wu_q <= wu_d;
    end
  end

  assign rx_en       = (st_q == PH_LISTEN) || (st_q == PH_PROLONG);
  assign phase       = st_q;
  assign outcome     = oc_q;
  assign outcome_vld = vld_q;
  assign host_irq    = irq_q;
endmodule

// File: rtl/rxwin_seq_chk.sv
module rxwin_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       wake,
  input logic       rx_en,
  input logic [2:0] phase,
  input logic [2:0] outcome,
  input logic       outcome_vld,
  input logic       host_irq
);
  assert_sleep_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && !(enable && wake)) |=> phase == 3'd0);

  assert_tune_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2) |-> ($past(phase) == 3'd1 || $past(phase) == 3'd2));

  assert_prolong_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4) |-> ($past(phase) == 3'd3 || $past(phase) == 3'd4));

  assert_busy_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == 3'd3 || phase == 3'd4) && wake) |=> phase != 3'd1);

  assert_vld_sleep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    outcome_vld |-> (!rx_en && phase == 3'd0 && $past(rx_en)));

  assert_close_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_en) |-> outcome_vld);

  assert_irq_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (outcome_vld && (outcome == 3'd1 || outcome == 3'd3)));

  assert_prolong_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome_vld && (outcome == 3'd3 || outcome == 3'd4)) |-> $past(phase) == 3'd4);

  assert_code_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    outcome_vld |-> outcome <= 3'd4);
endmodule

bind rxwin_seq rxwin_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wake(wake), .rx_en(rx_en),
  .phase(phase), .outcome(outcome), .outcome_vld(outcome_vld), .host_irq(host_irq)
);

// File: tb/rxwin_seq_tb_top.sv
`timescale 1ns/1ps
module rxwin_seq_tb_top;
  localparam int LEN_W = 8, EXP_W = 5, EXP_MAX = 20;
  localparam int XTAL_CYC = 20, TUNE_CYC = 7, SYNC_WAIT = 32;

  logic clk = 1'b0;
  logic rst_n, enable, wake, multi_pkt, preamble_det, sync_det, pkt_done, pkt_err;
  logic [EXP_W-1:0] win_exp;
  logic [LEN_W-1:0] win_len;
  logic rx_en, outcome_vld, host_irq;
  logic [2:0] phase, outcome;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rxwin_seq #(.LEN_W(LEN_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX), .XTAL_CYC(XTAL_CYC),
              .TUNE_CYC(TUNE_CYC), .SYNC_WAIT(SYNC_WAIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wake(wake), .multi_pkt(multi_pkt),
    .win_exp(win_exp), .win_len(win_len), .preamble_det(preamble_det),
    .sync_det(sync_det), .pkt_done(pkt_done), .pkt_err(pkt_err), .rx_en(rx_en),
    .phase(phase), .outcome(outcome), .outcome_vld(outcome_vld), .host_irq(host_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int win_cycles(input int len, input int ex);
    return ((len == 0) ? 1 : len) << (ex + 2);
  endfunction

  // Cycle-stepped model of the session rules (k = receiver-on cycle index)
  function automatic void model(input int len, input int ex, input bit mul,
                                input int p, input int s, input int d, input int e,
                                output int code, output int ncyc);
    int w = win_cycles(len, ex);
    bit pre = 0, syn = 0, prol = 0;
    int pk = 0;
    code = -1; ncyc = -1;
    for (int k = 0; k < 5000; k++) begin
      bit pp = (k == p), ss = (k == s), dd = (k == d), ee = (k == e);
      bit hexp = pre && !syn && (k >= pk + SYNC_WAIT);
      if (!prol) begin
        if (ee) code = 2;
        else if (dd) code = 1;
        else if (!mul && hexp && !ss) code = 2;
        else if (k == w - 1) begin
          if (syn || (pre && !hexp)) prol = 1;
          else code = 0;
        end
      end else begin
        if (ee) code = 4;
        else if (dd) code = 3;
        else if (hexp && !ss) code = 4;
      end
      if (code >= 0) begin
        ncyc = k + 1;
        return;
      end
      if (ss && pre) syn = 1;
      if (pp && !pre) begin pre = 1; pk = k; end
    end
  endfunction

  task automatic run_case(input int len, input int ex, input bit mul, input int p,
                          input int s, input int d, input int e,
                          input bit hold_pre, input bit wake_mid);
    int code, ncyc, k, w;
    bit ph_ok, prol_ph;
    model(len, ex, mul, p, s, d, e, code, ncyc);
    w = win_cycles(len, ex);
    @(negedge clk);
    win_len = LEN_W'(len); win_exp = EXP_W'(ex); multi_pkt = mul; wake = 1'b1;
    preamble_det = hold_pre; sync_det = hold_pre;
    @(negedge clk);
    wake = 1'b0;
    win_len = LEN_W'($urandom);           // R3: later changes must not matter
    win_exp = EXP_W'($urandom % 3);
    ph_ok = 1;
    for (int i = 1; i <= XTAL_CYC + TUNE_CYC; i++) begin
      if (phase != ((i <= XTAL_CYC) ? 3'd1 : 3'd2) || rx_en) ph_ok = 0;
      @(negedge clk);
    end
    chk(ph_ok && rx_en && phase == 3'd3, "R2 warm-up sequence", int'(phase), 3);
    k = 0; prol_ph = 0;
    while (rx_en && k < 5000) begin
      preamble_det = (k == p); sync_det = (k == s);
      pkt_done = (k == d); pkt_err = (k == e);
      wake = wake_mid && (k == 2);
      if (k == w) prol_ph = (phase == 3'd4);
      @(negedge clk);
      k++;
    end
    preamble_det = 0; sync_det = 0; pkt_done = 0; pkt_err = 0; wake = 0;
    chk(k == ncyc, "R3 receiver-on cycles", k, ncyc);
    case (code)
      0: chk(int'(outcome) == code, "R4 outcome OFF", int'(outcome), code);
      1: chk(int'(outcome) == code, "R5 outcome END", int'(outcome), code);
      2: chk(int'(outcome) == code, "R6 outcome ABORT", int'(outcome), code);
      default: chk(int'(outcome) == code, "R8 prolong outcome", int'(outcome), code);
    endcase
    if (ncyc > w) chk(prol_ph, "R7 prolong phase after window", int'(prol_ph), 1);
    chk(outcome_vld, "R12 outcome strobe", int'(outcome_vld), 1);
    chk(host_irq == (code == 1 || code == 3), "R12 host irq", int'(host_irq),
        int'(code == 1 || code == 3));
    @(negedge clk);
    chk(!outcome_vld && !host_irq && int'(outcome) == code, "R12 strobe single cycle",
        int'(outcome_vld), 0);
    if (wake_mid) begin
      ph_ok = 1;
      repeat (4) begin
        if (phase != 3'd0) ph_ok = 0;
        @(negedge clk);
      end
      chk(ph_ok, "R11 wake during session ignored", int'(phase), 0);
    end
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed);
    rst_n = 0; enable = 0; wake = 0; multi_pkt = 0; preamble_det = 0;
    sync_det = 0; pkt_done = 0; pkt_err = 0; win_exp = '0; win_len = 8'd1;
    repeat (3) @(negedge clk);
    chk(!rx_en && phase == 3'd0 && !outcome_vld && !host_irq, "R1 reset state",
        int'(phase), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rx_en && phase == 3'd0 && !outcome_vld, "R1 after release", int'(rx_en), 0);

    // R2: wake with enable low
    wake = 1;
    @(negedge clk);
    wake = 0;
    repeat (5) @(negedge clk);
    chk(phase == 3'd0 && !rx_en, "R2 wake ignored when disabled", int'(phase), 0);
    enable = 1;

    run_case(3, 0, 0, -1, -1, -1, -1, 0, 0);               // R4 OFF
    run_case(5, 1, 0, -1, -1, 10, -1, 0, 0);               // R5 END
    run_case(20, 1, 0, 5, -1, -1, -1, 0, 0);               // R6 sync wait runs out
    run_case(20, 1, 1, 5, -1, -1, -1, 0, 0);               // R9 multi-packet keeps listening
    run_case(2, 0, 0, 3, 6, 30, -1, 0, 0);                 // R7/R8 prolong end
    run_case(2, 0, 0, 3, 6, -1, 25, 0, 0);                 // R8 prolong error
    run_case(2, 0, 0, 5, -1, -1, -1, 0, 0);                // R8 prolong, sync never comes
    run_case(2, 0, 0, -1, -1, 7, -1, 0, 0);                // R10 done in last window cycle
    run_case(4, 0, 0, -1, -1, 4, 4, 0, 0);                 // R10 error beats done
    run_case(20, 1, 0, 2, 2 + SYNC_WAIT, 50, -1, 0, 0);    // R10 sync at run-out rescues
    run_case(0, 0, 0, -1, -1, -1, -1, 0, 0);               // R3 zero length counts as one
    run_case(3, 0, 0, -1, -1, -1, -1, 1, 0);               // R11 detections in warm-up ignored
    run_case(2, 0, 0, 3, 3, -1, -1, 0, 0);                 // R11 sync with preamble ignored
    run_case(6, 0, 0, -1, -1, 15, -1, 0, 1);               // R11 wake during session

    for (int n = 0; n < 80; n++) begin
      int len, ex, w, p, s, d, e;
      bit mul;
      len = 1 + int'($urandom % 15);
      ex = int'($urandom % 3);
      mul = 1'($urandom);
      w = win_cycles(len, ex);
      p = ($urandom % 3 == 0) ? -1 : int'($urandom % (w + 10));
      s = (p < 0 || $urandom % 4 == 0) ? -1 : p + 1 + int'($urandom % 40);
      if ($urandom % 2 == 0) begin
        d = int'($urandom % (w + 40)); e = -1;
      end else begin
        e = int'($urandom % (w + 40)); d = -1;
      end
      run_case(len, ex, mul, p, s, d, e, 0, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule